// File: doc/BRIEF.md
# Dual 8-bit Chainable Timer

This block holds two 8-bit up-counters. Each has its own clock choice, two compare values and an output pin. A counter can run as a square-wave divider, as a PWM generator whose duty is set by its two compares, or as a free-running counter that flags each wrap. The two counters can also be joined into one 16-bit counter. In that case the upper byte advances on each carry out of the lower byte, and the compare values are read as 16-bit pairs.

Software programs the block through a small write port. Each counter has two compare registers and a configuration register (clock choice and mode). One pair register holds a run bit and a chain bit. A control state machine has three states: `PAIR_HALT` (counters and outputs frozen), `PAIR_SPLIT` (two independent 8-bit counters) and `PAIR_CHAIN` (one 16-bit counter). Every write to the pair register moves the machine. With the run bit clear it goes to `PAIR_HALT`. With the run bit set it goes to `PAIR_CHAIN` if the chain bit is set, and to `PAIR_SPLIT` if not. That write also restarts both counters. Counter 0's compare-A match drives a converter start pulse and a toggling rate clock for a serial port.

Top module: `dual_tmr8`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output (`tmo`, `irq_cmpa`, `irq_cmpb`, `irq_ovf`, `adc_trig`, `ser_clk`) is 0.
- R2: Config field sel = cfg[2:0] picks a tick every 1, 2, 8, 32, 64, 1024 or 8192 clock cycles for values 0 to 6.
- R3: sel = 7 counts the `ext_clk` pin. The pin passes through a two-flop synchroniser and only its rising edges count, so a pin held high for several cycles gives one tick.
- R4: Mode cfg[4:3] = 1 (toggle): on a tick with the count equal to compare A, the count clears and `tmo` inverts, so each output level lasts A+1 ticks.
- R5: Mode 2 (PWM): a compare-A match clears the count and drives `tmo` high. A compare-B match drives it low. Period is A+1 ticks and high time is B+1 ticks. When B >= A the output stays high.
- R6: Mode 3 (free) wraps from 0xFF to 0, pulses `irq_ovf` every 256 ticks and leaves `tmo` unchanged. Mode 0 (off) holds the count at 0, `tmo` low and no match pulses.
- R7: `irq_cmpa[i]` and `irq_cmpb[i]` give a one-cycle pulse, one cycle after the ticked match on compare A or B of counter i.
- R8: Pair register (address 6) = run bit 0 | chain bit 1 << 1. In `PAIR_CHAIN`, counter 0's clock and mode drive a 16-bit count: {addr 2, addr 0} is compare A and {addr 3, addr 1} is compare B. `tmo[1]` and `irq_cmpa[1]` stay 0. `irq_ovf[0]` marks each lower-byte carry and `irq_ovf[1]` marks each 16-bit wrap.
- R9: `adc_trig` gives a one-cycle pulse on each counter-0 compare-A match (16-bit match when chained).
- R10: `ser_clk` inverts on each counter-0 compare-A match in every mode, so it runs at half the match rate.
- R11: In `PAIR_HALT` the counts and `tmo` hold their values and no match pulses appear.
- R12: A pair-register write with the run bit set clears both counts, `tmo` and `ser_clk`, visible the cycle after the write.
- R13: When compare A and compare B match on the same tick in PWM mode, compare A wins and the output stays high.
- R14: In `PAIR_SPLIT` the two counters run independently, each with its own clock choice and mode. Addresses: 0/1 hold compare A/B of counter 0, 2/3 hold compare A/B of counter 1, and 4/5 hold the configurations of counters 0/1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ext_clk | input | 1 | External count clock, asynchronous |
| tmo | output | 2 | Counter output pins |
| irq_cmpa | output | 2 | Compare-A match pulses |
| irq_cmpb | output | 2 | Compare-B match pulses |
| irq_ovf | output | 2 | Wrap pulses |
| adc_trig | output | 1 | Converter start pulse |
| ser_clk | output | 1 | Rate clock for a serial port |

## Verification
A count that is off by one, or a tick tap that is wrong, changes the measured `tmo` period and high time at the next compare-A match. That match lands at most A+1 ticks after a restart. A wrong control state shows within one cycle: frozen outputs that still move, `tmo[1]` activity while chained, or a `ser_clk` edge without a matching `adc_trig` pulse. A synchroniser that counts levels instead of edges doubles the tick rate from `ext_clk`, and this shows up as a halved divider period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        PAIR_HALT  = 2'd0,
        PAIR_SPLIT = 2'd1,
        PAIR_CHAIN = 2'd2
    } pair_state_e;

    typedef enum logic [1:0] {
        CM_OFF    = 2'd0,
        CM_TOGGLE = 2'd1,
        CM_PWM    = 2'd2,
        CM_FREE   = 2'd3
    } cnt_mode_e;

    localparam int SEL_W = 3;
    localparam int PRE_W = 13;
    localparam logic [SEL_W-1:0] SEL_EXT = 3'd7;

    // number of low prescaler bits that must all be ones for a tick
    function automatic int tap_bits(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 0;
            3'd1:    return 1;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 10;
            default: return 13;
        endcase
    endfunction

endpackage

// File: rtl/tmr_clkgen.sv
module tmr_clkgen
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk,
    output logic [PRE_W-1:0] pre,
    output logic             ext_rise
);
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre    <= '0;
            sync_q <= '0;
        end else begin
            pre    <= pre + 1'b1;
            sync_q <= {sync_q[1:0], ext_clk};
        end
    end

    // sync_q[1] is the second synchroniser flop, sync_q[2] its history
    assign ext_rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/tmr_tick.sv
module tmr_tick
    import tmr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [PRE_W-1:0] pre,
    input  logic             ext_rise,
    output logic             tick
);
    logic [PRE_W-1:0] mask;
    int               bits;

    always_comb begin
        bits = tap_bits(sel);
        for (int k = 0; k < PRE_W; k++) begin
            mask[k] = (k < bits);
        end
        tick = (sel == SEL_EXT) ? ext_rise : ((pre & mask) == mask);
    end
endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  cnt_mode_e    mode,
    input  logic         tick,
    input  logic         out_q,
    output logic [W-1:0] cnt_nxt,
    output logic         out_nxt,
    output logic         hit_a,
    output logic         hit_b,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_TOP = '1;

    logic live;
    logic clears;

    always_comb begin
        live    = tick && (mode != CM_OFF);
        hit_a   = live && (cnt == cmp_a);
        hit_b   = live && (cnt == cmp_b);
        clears  = hit_a && ((mode == CM_TOGGLE) || (mode == CM_PWM));
        wrap    = live && (cnt == CNT_TOP) && !clears;
        cnt_nxt = cnt;
        out_nxt = out_q;
        unique case (mode)
            CM_OFF: begin
                cnt_nxt = '0;
                out_nxt = 1'b0;
            end
            CM_FREE: begin
                if (live) cnt_nxt = cnt + 1'b1;
            end
            CM_TOGGLE: begin
                if (clears) begin
                    cnt_nxt = '0;
                    out_nxt = ~out_q;
                end else if (live) begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            CM_PWM: begin
                if (clears) begin
                    cnt_nxt = '0;
                    out_nxt = 1'b1;        // R13: compare A outranks compare B
                end else if (live) begin
                    cnt_nxt = cnt + 1'b1;
                    if (hit_b) out_nxt = 1'b0;
                end
            end
        endcase
    end
endmodule

// File: rtl/dual_tmr8.sv
module dual_tmr8
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              ext_clk,
    output logic [1:0]        tmo,
    output logic [1:0]        irq_cmpa,
    output logic [1:0]        irq_cmpb,
    output logic [1:0]        irq_ovf,
    output logic              adc_trig,
    output logic              ser_clk
);
    localparam int NCH    = 2;
    localparam int WIDE_W = NCH * CNT_W;
    localparam logic [ADDR_W-1:0] ADR_CFG0 = ADDR_W'(2 * NCH);
    localparam logic [ADDR_W-1:0] ADR_PAIR = ADDR_W'(3 * NCH);
    localparam logic [CNT_W-1:0]  LO_TOP   = '1;

    // configuration
    logic [NCH-1:0][CNT_W-1:0] cmp_a_q, cmp_b_q;
    logic [SEL_W-1:0]          sel_q  [NCH];
    cnt_mode_e                 mode_q [NCH];

    // control state
    pair_state_e state_q, state_d;
    logic        pair_wr, start;

    // datapath state
    logic [NCH-1:0][CNT_W-1:0] cnt_q, cnt_d;
    logic [NCH-1:0]            out_q, out_d;
    logic [NCH-1:0]            ha, hb, ov;
    logic                      ser_q;

    // per-counter results
    logic [PRE_W-1:0]          pre;
    logic                      ext_rise;
    logic [NCH-1:0]            tick;
    logic [NCH-1:0][CNT_W-1:0] n_cnt;
    logic [NCH-1:0]            n_out, n_ha, n_hb, n_wrap;

    // chained result
    logic [WIDE_W-1:0] w_cnt;
    logic              w_out, w_ha, w_hb, w_wrap;

    assign pair_wr = wr_en && (wr_addr == ADR_PAIR);
    assign start   = pair_wr && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_a_q <= '0;
            cmp_b_q <= '0;
            for (int i = 0; i < NCH; i++) begin
                sel_q[i]  <= '0;
                mode_q[i] <= CM_OFF;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == ADDR_W'(2 * i))     cmp_a_q[i] <= wr_data;
                if (wr_addr == ADDR_W'(2 * i + 1)) cmp_b_q[i] <= wr_data;
                if (wr_addr == ADR_CFG0 + ADDR_W'(i)) begin
                    sel_q[i]  <= wr_data[SEL_W-1:0];
                    mode_q[i] <= cnt_mode_e'(wr_data[SEL_W+1:SEL_W]);
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PAIR_HALT;
        else        state_q <= state_d;
    end

    // transitions: every pair write picks the next state
    always_comb begin
        state_d = state_q;
        if (pair_wr) begin
            if (!wr_data[0])     state_d = PAIR_HALT;
            else if (wr_data[1]) state_d = PAIR_CHAIN;
            else                 state_d = PAIR_SPLIT;
        end
    end

    tmr_clkgen u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk  (ext_clk),
        .pre      (pre),
        .ext_rise (ext_rise)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            tmr_tick u_tick (
                .sel      (sel_q[g]),
                .pre      (pre),
                .ext_rise (ext_rise),
                .tick     (tick[g])
            );
            tmr_step #(.W(CNT_W)) u_step (
                .cnt     (cnt_q[g]),
                .cmp_a   (cmp_a_q[g]),
                .cmp_b   (cmp_b_q[g]),
                .mode    (mode_q[g]),
                .tick    (tick[g]),
                .out_q   (out_q[g]),
                .cnt_nxt (n_cnt[g]),
                .out_nxt (n_out[g]),
                .hit_a   (n_ha[g]),
                .hit_b   (n_hb[g]),
                .wrap    (n_wrap[g])
            );
        end
    endgenerate

    tmr_step #(.W(WIDE_W)) u_wide (
        .cnt     (cnt_q),
        .cmp_a   (cmp_a_q),
        .cmp_b   (cmp_b_q),
        .mode    (mode_q[0]),
        .tick    (tick[0]),
        .out_q   (out_q[0]),
        .cnt_nxt (w_cnt),
        .out_nxt (w_out),
        .hit_a   (w_ha),
        .hit_b   (w_hb),
        .wrap    (w_wrap)
    );

    // output process: per-state next values
    always_comb begin
        cnt_d = cnt_q;
        out_d = out_q;
        ha    = '0;
        hb    = '0;
        ov    = '0;
        unique case (state_q)
            PAIR_HALT: begin
            end
            PAIR_SPLIT: begin
                cnt_d = n_cnt;
                out_d = n_out;
                ha    = n_ha;
                hb    = n_hb;
                ov    = n_wrap;
            end
            PAIR_CHAIN: begin
                cnt_d    = w_cnt;
                out_d    = {1'b0, w_out};
                ha       = {1'b0, w_ha};
                hb       = {1'b0, w_hb};
                ov[0]    = tick[0] && (mode_q[0] != CM_OFF) && (cnt_q[0] == LO_TOP);
                ov[1]    = w_wrap;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            out_q    <= '0;
            ser_q    <= 1'b0;
            irq_cmpa <= '0;
            irq_cmpb <= '0;
            irq_ovf  <= '0;
            adc_trig <= 1'b0;
        end else if (start) begin
            cnt_q    <= '0;
            out_q    <= '0;
            ser_q    <= 1'b0;
            irq_cmpa <= '0;
            irq_cmpb <= '0;
            irq_ovf  <= '0;
            adc_trig <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            out_q    <= out_d;
            ser_q    <= ser_q ^ ha[0];
            irq_cmpa <= ha;
            irq_cmpb <= hb;
            irq_ovf  <= ov;
            adc_trig <= ha[0];
        end
    end

    assign tmo     = out_q;
    assign ser_clk = ser_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [1:0]        tmo,
    input logic [1:0]        irq_cmpa,
    input logic              adc_trig,
    input logic              ser_clk,
    input logic [1:0]        state,
    input logic [1:0]        mode0
);
    localparam logic [ADDR_W-1:0] ADR_PAIR = ADDR_W'(6);

    logic restart;
    assign restart = wr_en && (wr_addr == ADR_PAIR) && wr_data[0];

    assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_HALT && $past(state == PAIR_HALT)) |-> ($stable(tmo) && irq_cmpa == 2'b00));

    assert_ser_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk != $past(ser_clk)) |-> (adc_trig || $past(restart)));

    assert_chain_upper_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_CHAIN) |-> (!tmo[1] && !irq_cmpa[1]));

    assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == PAIR_SPLIT && mode0 == CM_OFF) |-> (!tmo[0] && !irq_cmpa[0]));

    assert_restart_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tmo == 2'b00 && !ser_clk));
endmodule

bind dual_tmr8 tmr_pair_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tmo      (tmo),
    .irq_cmpa (irq_cmpa),
    .adc_trig (adc_trig),
    .ser_clk  (ser_clk),
    .state    (state_q),
    .mode0    (mode_q[0])
);

// File: tb/sim_dual_tmr8.sv
`timescale 1ns/1ps
module sim_dual_tmr8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ext_clk = 1'b0;
    logic [1:0] tmo, irq_cmpa, irq_cmpb, irq_ovf;
    logic       adc_trig, ser_clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dual_tmr8 u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ext_clk(ext_clk), .tmo(tmo), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb),
        .irq_ovf(irq_ovf), .adc_trig(adc_trig), .ser_clk(ser_clk)
    );

    // external clock: two cycles high, two low
    initial begin
        forever begin
            repeat (2) @(posedge clk);
            #1 ext_clk = ~ext_clk;
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (run) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // stimulus table: sel, mode, A, B, expected period, expected high time (cycles)
    localparam int NV = 10;
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 0, 7, 0};
    localparam int V_MODE[NV] = '{1, 1, 1, 1, 2, 1, 1, 2, 1, 2};
    localparam int V_A   [NV] = '{3, 2, 1, 0, 4, 0, 0, 9, 1, 255};
    localparam int V_B   [NV] = '{0, 0, 0, 0, 1, 0, 0, 2, 0, 127};
    localparam int V_PER [NV] = '{8, 12, 32, 64, 320, 2048, 16384, 10, 16, 256};
    localparam int V_HI  [NV] = '{4, 6, 16, 32, 128, 1024, 8192, 3, 8, 128};

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic sig(input int which);
        case (which)
            0:       return tmo[0];
            1:       return tmo[1];
            2:       return ser_clk;
            3:       return irq_cmpa[0];
            4:       return irq_cmpb[0];
            5:       return irq_ovf[0];
            default: return adc_trig;
        endcase
    endfunction

    // high time and rise-to-rise period of a signal, sampled at falling clock edges
    task automatic meas(input int which, input int lim, output int hi, output int per);
        int n = 0;
        int h = 0;
        int l = 0;
        hi  = -1;
        per = -1;
        while (sig(which) !== 1'b0 && n < lim) begin @(negedge clk); n++; end
        while (sig(which) !== 1'b1 && n < lim) begin @(negedge clk); n++; end
        while (sig(which) === 1'b1 && n < lim) begin @(negedge clk); n++; h++; end
        while (sig(which) === 1'b0 && n < lim) begin @(negedge clk); n++; l++; end
        if (n < lim) begin
            hi  = h;
            per = h + l;
        end
    endtask

    initial begin
        int hi, per, lows;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "outputs in reset", int'({tmo, irq_cmpa, irq_cmpb, irq_ovf, adc_trig, ser_clk}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", int'({tmo, irq_cmpa, irq_cmpb, irq_ovf, adc_trig, ser_clk}), 0);

        // table walk: R2 taps, R3 external clock, R4 toggle, R5 PWM
        for (int v = 0; v < NV; v++) begin
            wr(6, 0);
            wr(0, V_A[v]);
            wr(1, V_B[v]);
            wr(4, (V_MODE[v] << 3) | V_SEL[v]);
            wr(6, 1);
            meas(0, 4 * V_PER[v] + 100, hi, per);
            chk(V_SEL[v] == 7 ? "R3" : (V_MODE[v] == 2 ? "R5" : "R4"), $sformatf("row %0d period", v), per, V_PER[v]);
            chk("R2", $sformatf("row %0d high", v), hi, V_HI[v]);
        end

        // R7 / R9 / R10: pulses and rate clock, PWM A=9 B=4, divide by 1
        wr(6, 0); wr(0, 9); wr(1, 4); wr(4, (2 << 3) | 0); wr(6, 1);
        meas(3, 200, hi, per);
        chk("R7", "cmpa pulse width", hi, 1);
        chk("R7", "cmpa interval", per, 10);
        meas(4, 200, hi, per);
        chk("R7", "cmpb interval", per, 10);
        meas(6, 200, hi, per);
        chk("R9", "adc trigger interval", per, 10);
        meas(2, 200, hi, per);
        chk("R10", "ser_clk period", per, 20);

        // R13: A == B keeps output high; also B > A
        wr(6, 0); wr(0, 5); wr(1, 5); wr(6, 1);
        repeat (20) @(negedge clk);
        lows = 0;
        for (int k = 0; k < 100; k++) begin if (tmo[0] !== 1'b1) lows++; @(negedge clk); end
        chk("R13", "low cycles with A==B", lows, 0);
        wr(6, 0); wr(1, 8); wr(6, 1);
        repeat (20) @(negedge clk);
        lows = 0;
        for (int k = 0; k < 100; k++) begin if (tmo[0] !== 1'b1) lows++; @(negedge clk); end
        chk("R5", "low cycles with B>A", lows, 0);

        // R6: free mode wraps every 256 ticks, output unchanged
        wr(6, 0); wr(4, (3 << 3) | 0); wr(6, 1);
        meas(5, 1000, hi, per);
        chk("R6", "free wrap interval", per, 256);
        chk("R6", "free mode tmo", int'(tmo[0]), 0);
        // R6: off mode
        wr(6, 0); wr(4, 0); wr(6, 1);
        lows = 0;
        for (int k = 0; k < 300; k++) begin if (tmo[0] !== 1'b0 || irq_cmpa[0] !== 1'b0) lows++; @(negedge clk); end
        chk("R6", "off mode activity", lows, 0);

        // R14: independent counters, ch0 toggle A=3 div1, ch1 PWM A=7 B=3 div2
        wr(6, 0); wr(0, 3); wr(4, (1 << 3) | 0);
        wr(2, 7); wr(3, 3); wr(5, (2 << 3) | 1); wr(6, 1);
        meas(1, 200, hi, per);
        chk("R14", "counter1 period", per, 16);
        chk("R14", "counter1 high", hi, 8);
        meas(0, 200, hi, per);
        chk("R14", "counter0 period", per, 8);

        // R8: chained, 16-bit A = 0x0103, toggle, divide by 1
        wr(6, 0); wr(0, 8'h03); wr(2, 8'h01); wr(4, (1 << 3) | 0); wr(6, 3);
        meas(0, 2000, hi, per);
        chk("R8", "chained period", per, 520);
        chk("R8", "chained high", hi, 260);
        chk("R8", "upper output quiet", int'(tmo[1]), 0);
        wr(6, 0); wr(4, (3 << 3) | 0); wr(6, 3);
        meas(5, 1000, hi, per);
        chk("R8", "lower carry interval", per, 256);

        // R11 / R12: freeze then restart
        wr(6, 0); wr(0, 8'h40); wr(4, (1 << 3) | 0); wr(6, 1);
        lows = 0;
        while (tmo[0] !== 1'b1 && lows < 500) begin @(negedge clk); lows++; end
        wr(6, 0);
        lows = 0;
        for (int k = 0; k < 200; k++) begin if (tmo[0] !== 1'b1 || adc_trig !== 1'b0) lows++; @(negedge clk); end
        chk("R11", "frozen output changes", lows, 0);
        wr(6, 1);
        chk("R12", "tmo after restart", int'(tmo[0]), 0);
        chk("R12", "ser_clk after restart", int'(ser_clk), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule